// File: doc/BRIEF.md
# Four-Register Parallel I/O Interface

This block sits between a processor's I/O bus and one peripheral. It holds four registers: two data ports, a control word and a status word. A chip select and a two-bit register select choose one of them. A read strobe places the chosen register on the processor data bus and a write strobe loads it. The external address decoder drives the chip select, and the register-select bits come from the two lowest address lines.

The control word sets the direction of each port. Port A in input mode captures a byte from the device on a strobe, checks its even parity against a separate parity line and raises a data-ready flag. Port B in input mode follows its device pins on every clock. A port in output mode drives the value the processor last wrote. The status word reports data-ready and parity-error. Reading port A clears the first flag. Reading the status word clears the second.

The data bus is split into an input bus and a registered output bus, with an enable that is high only in the cycle after a selected read.

Top module: `quad_reg_pio`

## Requirements
- R1: After reset, every register is zero, the data output is zero with its enable low, and both ports are in input mode (both port enables low).
- R2: While chip select is low, read and write strobes have no effect on any register, and the output enable stays low.
- R3: A selected read in cycle t gives the register's pre-edge contents on the data output in cycle t+1, with the enable high in that cycle only. In every other cycle the data output is zero. Select codes: 00 port A, 01 port B, 10 control, 11 status.
- R4: A selected write to the control register loads all bits. Control bit 0 set makes port A an output (its enable high). Control bit 1 set does the same for port B.
- R5: In output mode, a write to a port register loads it and the value appears on that port's output pins. In input mode, a processor write to that port is ignored.
- R6: With port A in input mode, a device strobe captures the port A input byte, which can then be read back. In output mode the strobe is ignored.
- R7: With port B in input mode, port B's register takes the device input on every clock.
- R8: Status bit 0 (data-ready) is set by a port A capture and cleared by a selected read of port A. A capture in the same cycle wins.
- R9: Status bit 1 (parity error) is set by a capture whose eight data bits plus the parity line hold an odd number of ones. A selected status read clears it. A capture with bad parity in the same cycle wins. Other status bits read as zero.
- R10: The status register is read-only, and writes to select code 11 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select from the address decoder |
| rsel | input | 2 | Register select (low address bits) |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| bus_din | input | 8 | Data from the processor |
| bus_dout | output | 8 | Read data to the processor |
| bus_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A device input byte |
| pa_par | input | 1 | Port A parity line from the device |
| pa_stb | input | 1 | Port A device strobe (new byte) |
| pa_out | output | 8 | Port A output pins |
| pa_oe | output | 1 | Port A drive enable (output mode) |
| pb_in | input | 8 | Port B device input |
| pb_out | output | 8 | Port B output pins |
| pb_oe | output | 1 | Port B drive enable (output mode) |

## Verification
The assertions assume the processor never raises both read and write in the same selected cycle. One assertion states this, and the bench never drives the two together. The assertions also assume the inputs are settled at each rising edge, so the bench changes every input on the falling edge. The random stimulus mixes parity-good and parity-bad captures with reads that race them. This exercises the same-cycle set-versus-clear orderings of both status flags.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_PA   = 2'b00,
    SEL_PB   = 2'b01,
    SEL_CTL  = 2'b10,
    SEL_STAT = 2'b11
  } pio_sel_e;

  localparam int NUM_REGS    = 4;
  localparam int DIR_A_BIT   = 0;
  localparam int DIR_B_BIT   = 1;
  localparam int ST_RDY_BIT  = 0;
  localparam int ST_PERR_BIT = 1;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cs,
  input  logic [1:0]          rsel,
  input  logic                io_rd,
  input  logic                io_wr,
  output logic [NUM_REGS-1:0] wr_en,
  output logic [NUM_REGS-1:0] rd_en
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wr_en[i] = cs && io_wr && (rsel == 2'(i));
    assign rd_en[i] = cs && io_rd && (rsel == 2'(i));
  end

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (rst)
    cs |-> !(io_rd && io_wr)); // R3
endmodule

// File: rtl/pio_data_port.sv
module pio_data_port #(
  parameter int W       = 8,
  parameter bit STROBED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         out_mode,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_d,
  input  logic [W-1:0] dev_d,
  input  logic         dev_stb,
  output logic         capture,
  output logic [W-1:0] q
);
  if (STROBED) begin : g_strobed
    assign capture = !out_mode && dev_stb;
  end else begin : g_sampled
    assign capture = !out_mode;
  end

  always_ff @(posedge clk) begin
    if (rst)                     q <= '0;
    else if (capture)            q <= dev_d;
    else if (out_mode && bus_wr) q <= bus_d;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_mode && !bus_wr) |=> (q == $past(q))); // R5
  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (out_mode && bus_wr) |=> (q == $past(bus_d))); // R5

  if (STROBED) begin : g_chk_strobed
    AST_IN_NO_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!out_mode && !dev_stb) |=> (q == $past(q))); // R6
  end
endmodule

// File: rtl/pio_status.sv
module pio_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] cap_data,
  input  logic         cap_par,
  input  logic         rd_port,
  input  logic         rd_stat,
  output logic         rdy,
  output logic         perr
);
  logic odd_ones;
  assign odd_ones = ^{cap_data, cap_par};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy  <= 1'b0;
      perr <= 1'b0;
    end else begin
      if (cap)          rdy <= 1'b1;
      else if (rd_port) rdy <= 1'b0;
      if (cap && odd_ones) perr <= 1'b1;
      else if (rd_stat)    perr <= 1'b0;
    end
  end

  AST_RDY_SET: assert property (@(posedge clk) disable iff (rst)
    cap |=> rdy); // R8
  AST_RDY_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd_port && !cap) |=> !rdy); // R8
  AST_PERR_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !cap) |=> !perr); // R9
  AST_PERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cap && !rd_stat) |=> (perr == $past(perr))); // R9
endmodule

// File: rtl/quad_reg_pio.sv
module quad_reg_pio
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs,
  input  logic [1:0]   rsel,
  input  logic         io_rd,
  input  logic         io_wr,
  input  logic [W-1:0] bus_din,
  output logic [W-1:0] bus_dout,
  output logic         bus_oe,
  input  logic [W-1:0] pa_in,
  input  logic         pa_par,
  input  logic         pa_stb,
  output logic [W-1:0] pa_out,
  output logic         pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic         pb_oe
);
  localparam int STAT_PAD = W - 2;

  logic [NUM_REGS-1:0] wr_en, rd_en;
  logic [W-1:0]        ctl_q, a_q, b_q, stat_w, rd_mux;
  logic                a_cap, b_cap, rdy, perr;

  pio_decode u_dec (
    .clk(clk), .rst(rst), .cs(cs), .rsel(rsel), .io_rd(io_rd), .io_wr(io_wr),
    .wr_en(wr_en), .rd_en(rd_en)
  );

  always_ff @(posedge clk) begin
    if (rst)               ctl_q <= '0;
    else if (wr_en[SEL_CTL]) ctl_q <= bus_din;
  end

  pio_data_port #(.W(W), .STROBED(1'b1)) u_port_a (
    .clk(clk), .rst(rst), .out_mode(ctl_q[DIR_A_BIT]), .bus_wr(wr_en[SEL_PA]),
    .bus_d(bus_din), .dev_d(pa_in), .dev_stb(pa_stb), .capture(a_cap), .q(a_q)
  );

  pio_data_port #(.W(W), .STROBED(1'b0)) u_port_b (
    .clk(clk), .rst(rst), .out_mode(ctl_q[DIR_B_BIT]), .bus_wr(wr_en[SEL_PB]),
    .bus_d(bus_din), .dev_d(pb_in), .dev_stb(1'b0), .capture(b_cap), .q(b_q)
  );

  pio_status #(.W(W)) u_stat (
    .clk(clk), .rst(rst), .cap(a_cap), .cap_data(pa_in), .cap_par(pa_par),
    .rd_port(rd_en[SEL_PA]), .rd_stat(rd_en[SEL_STAT]), .rdy(rdy), .perr(perr)
  );

  assign stat_w = {{STAT_PAD{1'b0}}, perr, rdy};

  always_comb begin
    unique case (pio_sel_e'(rsel))
      SEL_PA:   rd_mux = a_q;
      SEL_PB:   rd_mux = b_q;
      SEL_CTL:  rd_mux = ctl_q;
      SEL_STAT: rd_mux = stat_w;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dout <= '0;
      bus_oe   <= 1'b0;
    end else begin
      bus_oe   <= cs && io_rd;
      bus_dout <= (cs && io_rd) ? rd_mux : '0;
    end
  end

  assign pa_out = a_q;
  assign pa_oe  = ctl_q[DIR_A_BIT];
  assign pb_out = b_q;
  assign pb_oe  = ctl_q[DIR_B_BIT];

  AST_OE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (cs && io_rd) |=> bus_oe); // R3
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(cs && io_rd) |=> !bus_oe); // R2
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_dout == '0)); // R3
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cs && io_wr && rsel == SEL_CTL) |=> $stable(ctl_q)); // R4
endmodule

// File: tb/quad_reg_pio_bench.sv
`timescale 1ns/1ps
module quad_reg_pio_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic cs = 0, io_rd = 0, io_wr = 0, pa_par = 0, pa_stb = 0;
  logic [1:0] rsel = 0;
  logic [7:0] bus_din = 0, pa_in = 0, pb_in = 0;
  logic [7:0] bus_dout, pa_out, pb_out;
  logic bus_oe, pa_oe, pb_oe;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] m_a = 0, m_b = 0, m_c = 0;
  logic m_rdy = 0, m_perr = 0;

  always #2.5 clk = ~clk;

  quad_reg_pio #(.W(8)) u_quad_reg_pio (
    .clk(clk), .rst(rst), .cs(cs), .rsel(rsel), .io_rd(io_rd), .io_wr(io_wr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .pa_in(pa_in), .pa_par(pa_par), .pa_stb(pa_stb), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  function automatic logic [7:0] model_read(input logic [1:0] s);
    case (s)
      2'b00:   return m_a;
      2'b01:   return m_b;
      2'b10:   return m_c;
      default: return {6'b0, m_perr, m_rdy};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, checks at the next falling edge.
  task automatic step(input logic c, input logic r, input logic w, input logic [1:0] s,
                      input logic [7:0] d, input logic stb, input logic [7:0] pa,
                      input logic par, input logic [7:0] pb, input string tag);
    logic [7:0] expd, na, nb, nc;
    logic cap, bad, nrdy, nperr;
    cs = c; io_rd = r; io_wr = w; rsel = s; bus_din = d;
    pa_stb = stb; pa_in = pa; pa_par = par; pb_in = pb;
    expd = (c && r) ? model_read(s) : 8'h00;
    cap = stb && !m_c[0];
    bad = ^{pa, par};
    na = cap ? pa : ((m_c[0] && c && w && s == 2'b00) ? d : m_a);
    nb = !m_c[1] ? pb : ((c && w && s == 2'b01) ? d : m_b);
    nc = (c && w && s == 2'b10) ? d : m_c;
    nrdy = cap ? 1'b1 : ((c && r && s == 2'b00) ? 1'b0 : m_rdy);
    nperr = (cap && bad) ? 1'b1 : ((c && r && s == 2'b11) ? 1'b0 : m_perr);
    m_a = na; m_b = nb; m_c = nc; m_rdy = nrdy; m_perr = nperr;
    @(negedge clk);
    chk(bus_oe == (c && r), c ? "R3" : "R2", {7'b0, bus_oe}, {7'b0, c && r});
    chk(bus_dout == expd, tag, bus_dout, expd);
    chk(pa_oe == m_c[0] && pb_oe == m_c[1], "R4", {6'b0, pb_oe, pa_oe}, {6'b0, m_c[1], m_c[0]});
    chk(pa_out == m_a && pb_out == m_b, "R5", pa_out ^ pb_out, m_a ^ m_b);
  endtask

  task automatic rd_reg(input logic [1:0] s, input string tag);
    step(1, 1, 0, s, 8'h00, 0, 8'h00, 0, pb_in, tag);
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d, input string tag);
    step(1, 0, 1, s, d, 0, 8'h00, 0, pb_in, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%h expected=%h", 8'h01, 8'h00);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state after reset
    chk(bus_dout == 0 && !bus_oe, "R1", bus_dout, 8'h00);
    chk(!pa_oe && !pb_oe && pa_out == 0 && pb_out == 0, "R1", pa_out | pb_out, 8'h00);
    rd_reg(2'b11, "R1");
    rd_reg(2'b10, "R1");
    // R2: deselected write to control, then readback
    step(0, 0, 1, 2'b10, 8'hA5, 0, 8'h00, 0, 8'h00, "R2");
    step(0, 1, 0, 2'b10, 8'h00, 0, 8'h00, 0, 8'h00, "R2");
    rd_reg(2'b10, "R2");
    // R6/R8: good-parity capture (four ones, parity 0)
    step(1, 0, 0, 2'b00, 8'h00, 1, 8'h3C, 0, 8'h00, "R6");
    rd_reg(2'b11, "R8");
    rd_reg(2'b00, "R6");
    rd_reg(2'b11, "R8");
    // R9: bad parity (one one, parity 0); first status read clears it
    step(1, 0, 0, 2'b00, 8'h00, 1, 8'h01, 0, 8'h00, "R9");
    rd_reg(2'b11, "R9");
    rd_reg(2'b11, "R9");
    // R9: bad parity while reading status: set wins
    step(1, 1, 0, 2'b11, 8'h00, 1, 8'h07, 0, 8'h00, "R9");
    rd_reg(2'b11, "R9");
    // R8: capture while reading port A: set wins
    step(1, 1, 0, 2'b00, 8'h00, 1, 8'h81, 0, 8'h00, "R8");
    rd_reg(2'b11, "R8");
    rd_reg(2'b00, "R8");
    // R10: status write ignored
    wr_reg(2'b11, 8'hFF, "R10");
    rd_reg(2'b11, "R10");
    // R5: write to port A in input mode ignored
    wr_reg(2'b00, 8'h55, "R5");
    rd_reg(2'b00, "R5");
    // R4/R5/R6: both ports to output
    wr_reg(2'b10, 8'h03, "R4");
    rd_reg(2'b10, "R4");
    wr_reg(2'b00, 8'h5A, "R5");
    wr_reg(2'b01, 8'hC3, "R5");
    step(1, 0, 0, 2'b00, 8'h00, 1, 8'h11, 1, 8'h00, "R6");
    rd_reg(2'b00, "R6");
    rd_reg(2'b11, "R6");
    // R7: port B back to input follows pins
    wr_reg(2'b10, 8'h00, "R7");
    step(0, 0, 0, 2'b00, 8'h00, 0, 8'h00, 0, 8'h77, "R7");
    rd_reg(2'b01, "R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic c, r, w, stb;
      int op;
      c = ($urandom_range(3) != 0);
      op = $urandom_range(2);
      r = (op == 1);
      w = (op == 2);
      stb = ($urandom_range(3) == 0);
      step(c, r, w, 2'($urandom_range(3)), 8'($urandom), stb, 8'($urandom),
           1'($urandom), 8'($urandom), "R3");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule